// File: doc/BRIEF.md
# Conditional Execution Flag Unit

This unit gates instruction execution in a small accumulator-style controller. It holds two execution flags, plus and minus, and for every instruction the core presents it reports whether that instruction may run. The decision depends on the instruction's 2-bit condition field, the flags, and, in run-once mode, a per-line memory of whether that line has already run.

Test instructions update the flags. Each test carries two 11-bit operands. An operand is either a signed immediate or a reference to one of eight registers, and the core supplies all eight register values on a packed input. The equal, greater and less tests always leave exactly one flag set. The three-way compare and its operand-swapped twin clear both flags on equality. A direct form loads both flags from two literal bits.

The core drives `issue` for one cycle per instruction. It reads `exec_en` in the same cycle. Any flag change is visible from the next cycle on.

Top module: `cond_flag_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, both flags read 0 and every line's run-once bit is clear.
- R2: `exec_en` is combinational and depends on `cond`. For `cond` 2'b00 it is 1. For 2'b01 it equals the minus flag. For 2'b10 it equals the plus flag.
- R3: For `cond` 2'b11, `exec_en` is 1 only while the run-once bit of `line` is clear. An issued instruction with cond 2'b11 that executes sets that bit, and bits of other lines are untouched.
- R4: The tests `test_op` 3'd1 (equal), 3'd2 (A greater than B) and 3'd3 (A less than B) set plus when the relation holds and minus when it does not.
- R5: The compare test `test_op` 3'd4 sets plus when A>B and minus when A<B. It clears both flags when A==B.
- R6: The reversed compare `test_op` 3'd5 behaves as 3'd4 with A and B swapped.
- R7: The direct-set test `test_op` 3'd6 loads plus from `set_plus` and minus from `set_minus`.
- R8: An operand whose bits [10:3] equal 8'b10000000 takes the value of register `opnd[2:0]`. That value is read from `reg_vals[11*k +: 11]` for register k. Any other operand is used as its own two's-complement value.
- R9: The flags change only on a clock edge where `issue` and `exec_en` are both 1 and `test_op` is 1 to 6. Codes 0 and 7 and non-executed tests leave both flags unchanged.
- R10: All comparisons are signed 11-bit comparisons.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | An instruction is presented this cycle |
| cond | input | 2 | Condition field of the instruction |
| test_op | input | 3 | Decoded test kind (0 = not a test) |
| opnd_a | input | 11 | First operand, immediate or register reference |
| opnd_b | input | 11 | Second operand, immediate or register reference |
| reg_vals | input | 88 | Eight 11-bit register values, register k at bits 11k+10..11k |
| set_plus | input | 1 | Plus value for the direct-set test |
| set_minus | input | 1 | Minus value for the direct-set test |
| line | input | LW | Program line index of the instruction |
| exec_en | output | 1 | Instruction may execute |
| flag_plus | output | 1 | Current plus flag |
| flag_minus | output | 1 | Current minus flag |

## Verification
The bench builds the unit with LINES set to 8. With that size, random line indices hit every run-once bit many times in a short run. The same test can then be retried on a line that has already run and on a fresh one. Register values are randomised across the full -999..999 range. Operands mix register references with immediates, so signed orderings and equal values through both decoding paths are covered.

// File: rtl/cond_flag_unit.sv
module cond_flag_unit #(
  parameter int LINES = 16,
  localparam int LW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [1:0]    cond,
  input  logic [2:0]    test_op,
  input  logic [10:0]   opnd_a,
  input  logic [10:0]   opnd_b,
  input  logic [87:0]   reg_vals,
  input  logic          set_plus,
  input  logic          set_minus,
  input  logic [LW-1:0] line,
  output logic          exec_en,
  output logic          flag_plus,
  output logic          flag_minus
);

  logic [LINES-1:0] done;
  logic signed [10:0] va, vb;
  logic nxt_p, nxt_m, upd;

  wire a_reg = (opnd_a[10:3] == 8'b1000_0000);
  wire b_reg = (opnd_b[10:3] == 8'b1000_0000);

  assign va = a_reg ? reg_vals[opnd_a[2:0]*11 +: 11] : opnd_a;
  assign vb = b_reg ? reg_vals[opnd_b[2:0]*11 +: 11] : opnd_b;

  always_comb begin
    case (cond)
      2'b00:   exec_en = 1'b1;
      2'b01:   exec_en = flag_minus;
      2'b10:   exec_en = flag_plus;
      default: exec_en = ~done[line];
    endcase
  end

  always_comb begin
    upd   = 1'b1;
    nxt_p = flag_plus;
    nxt_m = flag_minus;
    case (test_op)
      3'd1: begin nxt_p = (va == vb); nxt_m = (va != vb); end
      3'd2: begin nxt_p = (va >  vb); nxt_m = ~(va >  vb); end
      3'd3: begin nxt_p = (va <  vb); nxt_m = ~(va <  vb); end
      3'd4: begin nxt_p = (va >  vb); nxt_m = (va <  vb); end
      3'd5: begin nxt_p = (vb >  va); nxt_m = (vb <  va); end
      3'd6: begin nxt_p = set_plus;   nxt_m = set_minus;  end
      default: upd = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_plus  <= 1'b0;
      flag_minus <= 1'b0;
      done       <= '0;
    end else if (issue && exec_en) begin
      if (upd) begin
        flag_plus  <= nxt_p;
        flag_minus <= nxt_m;
      end
      if (cond == 2'b11) done[line] <= 1'b1;
    end
  end

endmodule

// File: rtl/cond_flag_unit_chk.sv
module cond_flag_unit_chk #(
  parameter int LINES = 16,
  localparam int LW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          issue,
  input logic [1:0]    cond,
  input logic [2:0]    test_op,
  input logic [LW-1:0] line,
  input logic          exec_en,
  input logic          flag_plus,
  input logic          flag_minus
);

  p_always_exec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cond == 2'b00 |-> exec_en);

  p_plus_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cond == 2'b10 && !flag_plus) |-> !exec_en);

  p_once_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && exec_en && cond == 2'b11) |=>
      (!(cond == 2'b11 && line == $past(line)) || !exec_en));

  p_one_hot_test_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && exec_en && (test_op inside {3'd1, 3'd2, 3'd3})) |=>
      $countones({flag_plus, flag_minus}) == 1);

  p_cmp_not_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && exec_en && (test_op inside {3'd4, 3'd5})) |=>
      $onehot0({flag_plus, flag_minus}));

  p_hold_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue || !exec_en || test_op == 3'd0 || test_op == 3'd7) |=>
      ($stable(flag_plus) && $stable(flag_minus)));

endmodule

bind cond_flag_unit cond_flag_unit_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue(issue), .cond(cond), .test_op(test_op),
  .line(line), .exec_en(exec_en), .flag_plus(flag_plus), .flag_minus(flag_minus)
);

// File: tb/sim_cond_flag_unit.sv
module sim_cond_flag_unit;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 8;
  localparam int LW = 3;

  logic clk = 0, rst_n = 0, issue = 0, set_plus = 0, set_minus = 0;
  logic [1:0] cond = 0;
  logic [2:0] test_op = 0;
  logic [10:0] opnd_a = 0, opnd_b = 0;
  logic [87:0] reg_vals = 0;
  logic [LW-1:0] line = 0;
  logic exec_en, flag_plus, flag_minus;

  int n_tests = 0, n_fail = 0;
  logic mp = 0, mm = 0;
  logic [LINES-1:0] mdone = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_flag_unit #(.LINES(LINES)) u0 (
    .clk(clk), .rst_n(rst_n), .issue(issue), .cond(cond), .test_op(test_op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .reg_vals(reg_vals), .set_plus(set_plus),
    .set_minus(set_minus), .line(line), .exec_en(exec_en),
    .flag_plus(flag_plus), .flag_minus(flag_minus));

  function automatic int value_of(logic [10:0] o, logic [87:0] rv);
    logic [10:0] w;
    if (o[10:3] == 8'b1000_0000) w = rv[o[2:0]*11 +: 11];
    else w = o;
    return int'($signed(w));
  endfunction

  function automatic logic exp_exec(logic [1:0] c, logic p, logic m, logic d);
    case (c)
      2'b00: return 1'b1;
      2'b01: return m;
      2'b10: return p;
      default: return ~d;
    endcase
  endfunction

  function automatic string req_of(logic [2:0] op, logic [10:0] a, logic [10:0] b);
    if (a[10:3] == 8'b1000_0000 || b[10:3] == 8'b1000_0000) return "R8";
    case (op)
      3'd1, 3'd2, 3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(logic iss, logic [1:0] c, logic [2:0] op, logic [10:0] a,
                      logic [10:0] b, logic sp, logic sm, logic [LW-1:0] ln, string rq);
    logic ee;
    int x, y;
    issue = iss; cond = c; test_op = op; opnd_a = a; opnd_b = b;
    set_plus = sp; set_minus = sm; line = ln;
    #1;
    ee = exp_exec(c, mp, mm, mdone[ln]);
    check((c == 2'b11) ? "R3" : "R2", {1'b0, exec_en}, {1'b0, ee});
    x = value_of(a, reg_vals);
    y = value_of(b, reg_vals);
    if (iss && ee) begin
      case (op)
        3'd1: begin mp = (x == y); mm = (x != y); end
        3'd2: begin mp = (x > y); mm = !(x > y); end
        3'd3: begin mp = (x < y); mm = !(x < y); end
        3'd4: begin mp = (x > y); mm = (x < y); end
        3'd5: begin mp = (y > x); mm = (y < x); end
        3'd6: begin mp = sp; mm = sm; end
        default: ;
      endcase
      if (c == 2'b11) mdone[ln] = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    check((rq != "") ? rq : ((iss && ee) ? req_of(op, a, b) : "R9"),
          {flag_plus, flag_minus}, {mp, mm});
  endtask

  function automatic logic [10:0] imm(int v);
    return 11'(v);
  endfunction

  function automatic logic [10:0] rnd_opnd();
    if ($urandom_range(0, 3) == 0) return {8'b1000_0000, 3'($urandom_range(0, 7))};
    return imm(int'($urandom_range(0, 1998)) - 999);
  endfunction

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int k = 0; k < 8; k++) reg_vals[k*11 +: 11] = imm(k * 100 - 350);
    @(negedge clk);
    check("R1", {flag_plus, flag_minus}, 2'b00);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", {flag_plus, flag_minus}, 2'b00);
    cond = 2'b11; line = 3'd5; #1;
    check("R1", {1'b0, exec_en}, 2'b01);

    step(1, 2'b01, 3'd6, 0, 0, 1, 1, 0, "R2");
    step(1, 2'b00, 3'd6, 0, 0, 1, 1, 0, "R7");
    step(1, 2'b00, 3'd4, imm(42), imm(42), 0, 0, 0, "R5");
    step(1, 2'b01, 3'd1, imm(1), imm(1), 0, 0, 0, "R9");
    step(1, 2'b00, 3'd4, imm(-5), imm(3), 0, 0, 0, "R10");
    step(1, 2'b00, 3'd2, imm(-5), imm(3), 0, 0, 0, "R10");
    step(1, 2'b00, 3'd5, imm(-5), imm(3), 0, 0, 0, "R6");
    step(1, 2'b00, 3'd3, imm(999), imm(-999), 0, 0, 0, "R10");
    step(1, 2'b00, 3'd1, {8'b1000_0000, 3'd3}, imm(-50), 0, 0, 0, "R8");
    step(1, 2'b00, 3'd4, imm(250), {8'b1000_0000, 3'd6}, 0, 0, 0, "R8");
    step(1, 2'b00, 3'd0, imm(5), imm(1), 0, 0, 0, "R9");
    step(1, 2'b00, 3'd7, imm(5), imm(1), 0, 0, 0, "R9");
    step(0, 2'b00, 3'd6, 0, 0, 0, 0, 0, "R9");
    step(1, 2'b11, 3'd6, 0, 0, 1, 0, 3'd2, "R3");
    step(1, 2'b11, 3'd6, 0, 0, 0, 1, 3'd2, "R3");
    step(1, 2'b11, 3'd6, 0, 0, 0, 1, 3'd3, "R3");
    step(1, 2'b11, 3'd0, 0, 0, 0, 0, 3'd3, "R3");

    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 15) == 0)
        for (int k = 0; k < 8; k++)
          reg_vals[k*11 +: 11] = imm(int'($urandom_range(0, 1998)) - 999);
      step($urandom_range(0, 7) != 0, 2'($urandom_range(0, 3)),
           3'($urandom_range(0, 7)), rnd_opnd(), rnd_opnd(),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           LW'($urandom_range(0, LINES - 1)), "");
      if ($urandom_range(0, 4) == 0) begin
        logic [10:0] v = rnd_opnd();
        step(1, 2'b00, 3'($urandom_range(1, 5)), v, v, 0, 0, 0, "");
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule